// File: doc/BRIEF.md
# Asynchronous Bus Master Cycle Sequencer

This block runs single read and write transfers on a 16-bit asynchronous, strobe-based bus, acting as the bus master. A host hands it one transfer at a time through a request port: a byte address, a write flag, a word/byte flag and the write data. The sequencer then steps through eight half-clock states. It drives the word address, the address strobe, the upper and lower data strobes, the active-low read/write line and the data-out enable. It stretches the transfer while the slave holds its acknowledge high. When the transfer ends, it returns the read data and a one-cycle completion pulse.

Each half-clock state lasts one period of `clk`. A transfer with a prompt acknowledge therefore occupies eight clocks, and every wait state adds two. Reads open the address and data strobes together. Writes open the data strobes one bus clock (two half-states) after the address strobe, so the write data is already stable when a slave latches it on the data strobe. The byte address bit 0 is never driven onto the bus. It only chooses the data strobe of a byte transfer. The bus inputs are assumed to be synchronous to `clk`.

Top module: `bms_bus_master`

## Requirements
- R1: While `rst_n` is low and after its release with no request, `bus_as_n`, `bus_uds_n`, `bus_lds_n` and `bus_rw_n` are 1, `bus_doe` and `rsp_done` are 0, and `req_ready` is 1.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. If `bus_dtack_n` is low when first sampled, `rsp_done` is high during the 9th clock after that edge, so the transfer spans eight half-clock states.
- R3: On a read (`req_write`=0), `bus_as_n` and the selected data strobes fall on the same clock, the 3rd after the accepting edge, and `bus_rw_n` stays 1 for the whole transfer.
- R4: On a write, `bus_rw_n` falls together with `bus_as_n` (3rd clock), `bus_doe` rises one clock later with `bus_dout` equal to the request's write data, and the data strobes fall two clocks after `bus_as_n`.
- R5: `bus_dtack_n` is sampled at the end of the 5th half-state and again every second clock after that while it reads high. Each high sample adds two clocks to the transfer. Strobes, `bus_rw_n` and `bus_addr` hold steady throughout.
- R6: Lane selection: when `req_word`=1, both strobes are used and address bit 0 is ignored. When `req_word`=0, bit 0 = 0 uses only `bus_uds_n` (D15..D8) and bit 0 = 1 uses only `bus_lds_n` (D7..D0).
- R7: `rsp_rdata` on a read holds the `bus_din` value present in the last half-state, with each unselected byte lane forced to zero. It is valid while `rsp_done` is high.
- R8: In the clock where `rsp_done` is high, all strobes are 1 and `bus_rw_n` is 1. On a write, `bus_doe` is still 1 in that clock and is 0 in the next one.
- R9: `req_ready` is 0 from the accepting edge until the transfer ends. A `req_valid` raised in that interval starts no transfer and does not disturb the address.
- R10: `bus_addr` equals bits [AW-1:1] of the accepted `req_addr` for as long as `bus_as_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period per half-clock bus state |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host offers a transfer |
| req_ready | output | 1 | Sequencer idle and able to take a transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit transfer, 0 = single byte |
| req_addr | input | AW | Byte address; bit 0 picks the lane of a byte transfer |
| req_wdata | input | DW | Write data, placed on lanes by the host |
| rsp_done | output | 1 | One-clock pulse when the transfer has ended |
| rsp_rdata | output | DW | Captured read data, unselected lanes zero |
| bus_addr | output | AW-1 | Word address on the bus |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_uds_n | output | 1 | Upper data strobe (D15..D8), active low |
| bus_lds_n | output | 1 | Lower data strobe (D7..D0), active low |
| bus_rw_n | output | 1 | High = read, low = write |
| bus_dout | output | DW | Write data toward the bus |
| bus_doe | output | 1 | Enable for the write data drivers |
| bus_din | input | DW | Read data from the bus |
| bus_dtack_n | input | 1 | Slave acknowledge, active low |

## Verification
The bench steers the acknowledge latency across the sampling boundary. A latency that just makes the first sample must give zero wait states, and one past it must give exactly one. A sequencer that samples a half-state early or late, or that adds one clock per wait instead of two, shifts the completion pulse. Writes are checked for the strobe order: a design that opened the data strobes with the address strobe, or dropped the data enable together with the strobes, fails the timing checks. Odd-address word transfers and both byte lanes are covered, so a design that lets bit 0 leak into word transfers or swaps lanes shows the wrong strobe or the wrong masked read data. The bench also changes the bus data outside the strobe window, which exposes a capture taken on the wrong edge. It raises stray requests mid-transfer to catch a sequencer that restarts or moves the address.

// File: rtl/bms_pkg.sv
package bms_pkg;

  // One entry per half-clock bus state plus idle and tail.
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_S0,
    ST_S1,
    ST_S2,
    ST_S3,
    ST_S4,
    ST_W0,
    ST_W1,
    ST_S5,
    ST_S6,
    ST_S7,
    ST_TAIL
  } bus_state_e;

  // Output intentions for a state, before the transfer type is applied.
  typedef struct packed {
    logic addr_strobe;
    logic rd_data_strobe;
    logic wr_data_strobe;
    logic rw_low;
    logic drive_data;
  } phase_t;

  // Strobed window: S2 up to and including S7, wait states included.
  function automatic logic in_strobe_window(bus_state_e s);
    case (s)
      ST_S2, ST_S3, ST_S4, ST_W0, ST_W1, ST_S5, ST_S6, ST_S7: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Write data strobes open two half-states after the address strobe.
  function automatic logic in_late_window(bus_state_e s);
    case (s)
      ST_S4, ST_W0, ST_W1, ST_S5, ST_S6, ST_S7: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Write drivers run from S3 until one half-state after the strobes end.
  function automatic logic in_drive_window(bus_state_e s);
    case (s)
      ST_S3, ST_S4, ST_W0, ST_W1, ST_S5, ST_S6, ST_S7, ST_TAIL: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic phase_t phase_of(bus_state_e s);
    phase_t p;
    p.addr_strobe    = in_strobe_window(s);
    p.rd_data_strobe = in_strobe_window(s);
    p.wr_data_strobe = in_late_window(s);
    p.rw_low         = in_strobe_window(s);
    p.drive_data     = in_drive_window(s);
    return p;
  endfunction

  // Lane pick: {upper, lower}. Word ignores bit 0; even byte is upper.
  function automatic logic [1:0] lane_pick(logic word, logic a0);
    if (word) return 2'b11;
    return a0 ? 2'b01 : 2'b10;
  endfunction

  // Number of clocks a transfer lasts from the accepting edge to done.
  function automatic int unsigned clocks_to_done(int unsigned waits);
    return 9 + 2 * waits;
  endfunction

endpackage

// File: rtl/bms_sequencer.sv
module bms_sequencer
  import bms_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       dtack_n,
  output bus_state_e state,
  output phase_t     phase,
  output logic       idle,
  output logic       sample_point,
  output logic       dtack_seen,
  output logic       cycle_end,
  output logic       done
);

  bus_state_e nxt;

  // Acknowledge is looked at when leaving S4 and when leaving each second wait half.
  assign sample_point = (state == ST_S4) || (state == ST_W1);
  assign dtack_seen   = sample_point && !dtack_n;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (start) nxt = ST_S0;
      ST_S0:   nxt = ST_S1;
      ST_S1:   nxt = ST_S2;
      ST_S2:   nxt = ST_S3;
      ST_S3:   nxt = ST_S4;
      ST_S4:   nxt = dtack_seen ? ST_S5 : ST_W0;
      ST_W0:   nxt = ST_W1;
      ST_W1:   nxt = dtack_seen ? ST_S5 : ST_W0;
      ST_S5:   nxt = ST_S6;
      ST_S6:   nxt = ST_S7;
      ST_S7:   nxt = ST_TAIL;
      ST_TAIL: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign phase     = phase_of(state);
  assign idle      = (state == ST_IDLE);
  assign cycle_end = (state == ST_S7);
  assign done      = (state == ST_TAIL);

  // R5: a wait half W0 is always followed by W1
  a_r5_wait_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_W0) |=> (state == ST_W1));

  // R2: leaving S4 with acknowledge low goes straight to S5
  a_r2_no_wait_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_S4) && !dtack_n) |=> (state == ST_S5));

endmodule

// File: rtl/bms_lane_ctl.sv
module bms_lane_ctl
  import bms_pkg::*;
(
  input  logic word,
  input  logic a0,
  output logic upper,
  output logic lower
);

  logic [1:0] pick;

  assign pick  = lane_pick(word, a0);
  assign upper = pick[1];
  assign lower = pick[0];

  // R6: some lane is always chosen
  always_comb begin
    a_r6_lane_nonempty: assert (upper || lower);
  end

endmodule

// File: rtl/bms_rd_capture.sv
module bms_rd_capture #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [1:0]    lanes,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] rdata
);

  localparam int LANES = 2;
  localparam int LW    = DW / LANES;

  logic [DW-1:0] masked;

  // lanes[1] is the upper half, lanes[0] the lower half
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign masked[g*LW +: LW] = lanes[g] ? din[g*LW +: LW] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (capture) rdata <= masked;
  end

endmodule

// File: rtl/bms_bus_master.sv
module bms_bus_master
  import bms_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_word,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:1] bus_addr,
  output logic          bus_as_n,
  output logic          bus_uds_n,
  output logic          bus_lds_n,
  output logic          bus_rw_n,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  input  logic [DW-1:0] bus_din,
  input  logic          bus_dtack_n
);

  localparam int WAW = AW - 1;

  bus_state_e state;
  phase_t     phase;
  logic       idle;
  logic       sample_point;
  logic       dtack_seen;
  logic       cycle_end;
  logic       done;
  logic       accept;
  logic       up_sel;
  logic       lo_sel;
  logic       ds_on;
  logic       read_capture;

  logic [WAW-1:0] addr_q;
  logic [DW-1:0]  wdata_q;
  logic           wr_q;
  logic [1:0]     lanes_q;

  assign accept = req_valid && idle;

  bms_sequencer i_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (accept),
    .dtack_n      (bus_dtack_n),
    .state        (state),
    .phase        (phase),
    .idle         (idle),
    .sample_point (sample_point),
    .dtack_seen   (dtack_seen),
    .cycle_end    (cycle_end),
    .done         (done)
  );

  bms_lane_ctl i_lane (
    .word  (req_word),
    .a0    (req_addr[0]),
    .upper (up_sel),
    .lower (lo_sel)
  );

  // Request register: taken only on acceptance, held for the whole transfer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      lanes_q <= 2'b00;
    end else if (accept) begin
      addr_q  <= req_addr[AW-1:1];
      wdata_q <= req_wdata;
      wr_q    <= req_write;
      lanes_q <= {up_sel, lo_sel};
    end
  end

  assign read_capture = cycle_end && !wr_q;

  bms_rd_capture #(.DW(DW)) i_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (read_capture),
    .lanes   (lanes_q),
    .din     (bus_din),
    .rdata   (rsp_rdata)
  );

  assign ds_on     = wr_q ? phase.wr_data_strobe : phase.rd_data_strobe;
  assign bus_addr  = addr_q;
  assign bus_as_n  = !phase.addr_strobe;
  assign bus_uds_n = !(ds_on && lanes_q[1]);
  assign bus_lds_n = !(ds_on && lanes_q[0]);
  assign bus_rw_n  = !(wr_q && phase.rw_low);
  assign bus_doe   = wr_q && phase.drive_data;
  assign bus_dout  = wdata_q;
  assign req_ready = idle;
  assign rsp_done  = done;

  // R3: a read opens a data strobe with the address strobe
  a_r3_read_together: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_as_n) && bus_rw_n) |-> !(bus_uds_n && bus_lds_n));

  // R4: a write keeps the data strobes closed when the address strobe opens
  a_r4_write_ds_closed: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_as_n) && !bus_rw_n) |-> (bus_uds_n && bus_lds_n));

  // R4: write data strobes open two half-states after the address strobe
  a_r4_write_ds_late: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rw_n && $fell(bus_uds_n && bus_lds_n)) |-> $past(!bus_as_n, 2));

  // R4: write drivers are on before the data strobes open
  a_r4_data_before_ds: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rw_n && $fell(bus_uds_n && bus_lds_n)) |-> $past(bus_doe));

  // R5, R10: address stays put while the strobe is held
  a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_as_n && $past(!bus_as_n)) |-> $stable(bus_addr));

  // R5: a high acknowledge sample keeps the strobes on
  a_r5_strobe_held: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_point && !dtack_seen) |=> (!bus_as_n && $stable(bus_uds_n) && $stable(bus_lds_n)));

  // R8: strobe release coincides with done and R/W* high
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_as_n) |-> (rsp_done && bus_rw_n && bus_uds_n && bus_lds_n));

  // R8: write drivers outlast the strobes by exactly one half-state
  a_r8_doe_tail: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_as_n) && $past(!bus_rw_n)) |-> (bus_doe ##1 !bus_doe));

  // R9: no new transfer while one is running
  a_r9_busy_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !rsp_done) |=> !req_ready);

  // R6: at most the two data strobes, never a strobe without the address strobe
  a_r6_ds_inside_as: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_uds_n && bus_lds_n) |-> !bus_as_n);

endmodule

// File: tb/test_bms_bus_master.sv
module test_bms_bus_master;

  localparam int AW = 24;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic          req_word = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:1] bus_addr;
  logic          bus_as_n, bus_uds_n, bus_lds_n, bus_rw_n, bus_doe;
  logic [DW-1:0] bus_dout;
  logic [DW-1:0] bus_din = '0;
  logic          bus_dtack_n = 1'b1;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  bms_bus_master #(.AW(AW), .DW(DW)) i_bms_bus_master (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bus_as_n(bus_as_n), .bus_uds_n(bus_uds_n),
    .bus_lds_n(bus_lds_n), .bus_rw_n(bus_rw_n), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .bus_din(bus_din), .bus_dtack_n(bus_dtack_n)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish (actual=%0d expected<150000)", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected wait states for a slave acking on its lat-th strobed negedge.
  function automatic int waits_for(int lat);
    if (lat <= 3) return 0;
    return (lat - 2) / 2;
  endfunction

  function automatic logic [1:0] lanes_for(bit word, bit a0);
    if (word) return 2'b11;
    return a0 ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [15:0] masked(logic [15:0] d, logic [1:0] ln);
    return {ln[1] ? d[15:8] : 8'h00, ln[0] ? d[7:0] : 8'h00};
  endfunction

  task automatic run_txn(input bit wr, input bit word, input logic [AW-1:0] a,
                         input logic [15:0] wd, input logic [15:0] rd,
                         input int lat, input bit poke);
    int as_t = -1, ds_t = -1, rw_t = -1, doe_t = -1, done_t = -1;
    int cnt = 0;
    bit addr_bad = 0, lane_bad = 0, dout_bad = 0, ready_bad = 0, rw_bad = 0;
    logic [1:0] ln;
    int w;
    ln = lanes_for(word, a[0]);
    w  = waits_for(lat);
    @(negedge clk);
    chk(req_ready === 1'b1, "R9 ready before request", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_word = word; req_addr = a; req_wdata = wd;
    @(negedge clk);
    if (poke) begin
      req_addr = ~a; req_wdata = ~wd; req_write = ~wr;
    end else begin
      req_valid = 1'b0;
    end
    for (int t = 1; t < 80; t++) begin
      if (!bus_as_n && as_t < 0) as_t = t;
      if (!(bus_uds_n && bus_lds_n) && ds_t < 0) ds_t = t;
      if (!bus_rw_n && rw_t < 0) rw_t = t;
      if (bus_doe && doe_t < 0) doe_t = t;
      if (!bus_as_n && bus_addr !== a[AW-1:1]) addr_bad = 1;
      if (!(bus_uds_n && bus_lds_n) && ({!bus_uds_n, !bus_lds_n} !== ln)) lane_bad = 1;
      if (bus_doe && bus_dout !== wd) dout_bad = 1;
      if (!wr && !bus_rw_n) rw_bad = 1;
      if (req_ready !== 1'b0) ready_bad = 1;
      if (rsp_done) begin
        done_t = t;
        break;
      end
      // slave model
      if (!bus_as_n) cnt++;
      bus_dtack_n = !(!bus_as_n && cnt >= lat);
      bus_din = !bus_as_n ? rd : 16'($urandom);
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(done_t == 9 + 2 * w, $sformatf("R2/R5 done time lat=%0d", lat), done_t, 9 + 2 * w);
    chk(as_t == 3, "R3/R4 address strobe time", as_t, 3);
    chk(!addr_bad, "R10 address while strobed", addr_bad, 0);
    chk(!lane_bad, "R6 lane strobes", lane_bad, 0);
    chk(!ready_bad, "R9 ready low while busy", ready_bad, 0);
    if (wr) begin
      chk(rw_t == 3, "R4 rw low with strobe", rw_t, 3);
      chk(doe_t == 4, "R4 drivers on", doe_t, 4);
      chk(ds_t == 5, "R4 write data strobe time", ds_t, 5);
      chk(!dout_bad, "R4 write data value", dout_bad, 0);
      chk(bus_doe === 1'b1, "R8 drivers held at done", bus_doe, 1);
    end else begin
      chk(ds_t == 3, "R3 read data strobe time", ds_t, 3);
      chk(!rw_bad, "R3 rw stays high", rw_bad, 0);
      chk(rsp_rdata === masked(rd, ln), "R7 read data", rsp_rdata, masked(rd, ln));
    end
    chk(bus_as_n && bus_uds_n && bus_lds_n && bus_rw_n, "R8 released at done",
        {bus_as_n, bus_uds_n, bus_lds_n, bus_rw_n}, 4'hf);
    bus_dtack_n = 1'b1;
    bus_din = 16'($urandom);
    @(negedge clk);
    chk(bus_doe === 1'b0, "R8 drivers off after done", bus_doe, 0);
    chk(req_ready === 1'b1, "R9 ready after transfer", req_ready, 1);
    if (poke) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(bus_as_n === 1'b1, "R9 stray request started nothing", bus_as_n, 1);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk({bus_as_n, bus_uds_n, bus_lds_n, bus_rw_n} === 4'hf, "R1 strobes in reset",
        {bus_as_n, bus_uds_n, bus_lds_n, bus_rw_n}, 4'hf);
    chk(bus_doe === 1'b0 && rsp_done === 1'b0, "R1 enables in reset", {bus_doe, rsp_done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready === 1'b1 && bus_as_n === 1'b1, "R1 idle after reset", {req_ready, bus_as_n}, 2'b11);

    // directed corners
    run_txn(0, 1, 24'h00_8001, 16'h0, 16'hA55A, 1, 0);  // word at odd address, R6
    run_txn(0, 0, 24'h00_8000, 16'h0, 16'h1234, 3, 0);  // upper byte, last zero-wait lat
    run_txn(0, 0, 24'h00_8003, 16'h0, 16'hBEEF, 4, 0);  // lower byte, one wait
    run_txn(1, 1, 24'h12_3456, 16'hC0DE, 16'h0, 1, 1);  // write, stray request
    run_txn(1, 0, 24'h12_3457, 16'h00F1, 16'h0, 5, 0);  // lower byte write, one wait
    run_txn(1, 0, 24'h12_3458, 16'h9900, 16'h0, 8, 1);  // upper byte write, three waits
    run_txn(0, 1, 24'hFF_FFFE, 16'h0, 16'h7E81, 6, 1);  // two waits, stray request

    for (int n = 0; n < 60; n++) begin
      run_txn(1'($urandom), 1'($urandom), 24'($urandom), 16'($urandom), 16'($urandom),
              1 + int'($urandom % 9), 1'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule